// File: doc/BRIEF.md
# Memory Access Error Responder

This block stands between the requesting ports of a system bus and an on-chip memory region. The region holds read-only storage, a set of SRAM banks that each may have error correction switched on, and address holes that map to nothing. Every access arrives with the number of the port that issued it. The block decodes the address and refuses forbidden accesses with an error response. It forwards legal accesses to the memory and reports any uncorrectable check-bit error that the memory flags on a read. The memory corrects single-bit errors on its own side, so those never reach the block as errors.

Check bits cover a whole 32-bit word. A write that does not carry all four byte enables into a protected bank therefore becomes a read of the full word, a byte merge and a full-word write-back. If that read returns an uncorrectable error, the write-back is dropped and the write is answered with an error.

Every port has one capture slot per error class. A slot holds the byte address of the first failing access and whether that access was a write, until a clear request empties it.

Top module: `mem_err_responder`

## Requirements
- R1: A write whose address bits [15:12] equal 0 (the read-only region) is answered with an error and issues no memory access. A read from that region is a normal memory read.
- R2: Any access whose address bits [15:12] are 2 or higher (the holes) is answered with an error and issues no memory access.
- R3: A read from a bank with its `ecc_en` bit set is answered with an error when `mem_ecc_multi` is high in the cycle after the read is issued. In a bank with its `ecc_en` bit clear, that flag is ignored. The SRAM region is bits [15:12] equal to 1, and the bank is address bits [11:10].
- R4: A write with `req_be` not equal to 4'hF into a protected bank first reads the word. It then writes back one full word (`mem_be` = 4'hF) in which lanes with a set enable bit take the new byte and all other lanes keep the old byte.
- R5: If the read of such a read-modify-write returns `mem_ecc_multi` high, no write is issued, the memory word stays unchanged and the write is answered with an error.
- R6: `rsp_rdata` carries the memory word on a successful read and is zero on every error response and on every write response.
- R7: A write with all four enables set, or any write into an unprotected SRAM bank or a legal region, is one memory write with `mem_be` equal to `req_be` and no read.
- R8: An error is recorded in slot index port*2+type. Type 0 is an illegal access (R1 or R2) and type 1 is an uncorrectable check-bit error (R3 or R5). The slot stores the full byte address and the write flag.
- R9: A valid slot keeps its first contents. A later error of the same port and type does not overwrite it.
- R10: A clear request empties the named slot one cycle later. When a clear and a new error for the same slot fall on the same clock edge, the slot ends up valid and holds the new error.
- R11: `req_ready` is high only when idle. The response comes one cycle after acceptance for illegal accesses and direct writes, and two cycles after for reads and read-modify-writes. `req_ready` is low in the response cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ecc_en | input | 4 | Per-bank check-bit protection enable |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Block can accept a request |
| req_port | input | 2 | Number of the requesting port |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Byte address |
| req_be | input | 4 | Byte lane enables for writes |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_err | output | 1 | Response is a bus error |
| rsp_rdata | output | 32 | Read data |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write when high, read when low |
| mem_addr | output | 14 | Memory word address |
| mem_be | output | 4 | Memory byte lane enables |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after a read strobe |
| mem_ecc_multi | input | 1 | Uncorrectable error flag, aligned with `mem_rdata` |
| clr_valid | input | 1 | Clear one capture slot |
| clr_port | input | 2 | Port of the slot to clear |
| clr_type | input | 1 | Error type of the slot to clear |
| cap_valid | output | 8 | Slot holds an unread error, index port*2+type |
| cap_addr | output | 128 | Captured byte addresses, 16 bits per slot |
| cap_wr | output | 8 | Captured write flag per slot |

## Verification
Two functions can meet on the same edge: a software clear of a capture slot, and the capture of a new error into that same slot. The bench provokes this on purpose. It raises the clear for exactly the slot that the pending error response will fill, in the response cycle, for both an illegal access and a failed read-modify-write. It then judges the slot on the next cycle, which must be valid and hold the new address and write flag. Random clears are also mixed with the random access stream, so the two paths coincide on other slots and on other ports as well.

// File: rtl/mer_pkg.sv
package mer_pkg;

    parameter int unsigned AW         = 16;
    parameter int unsigned DW         = 32;
    parameter int unsigned NBE        = DW / 8;
    parameter int unsigned NPORTS     = 4;
    parameter int unsigned PW         = $clog2(NPORTS);
    parameter int unsigned REGION_LSB = 12;
    parameter int unsigned RGW        = AW - REGION_LSB;
    parameter int unsigned NBANKS     = 4;
    parameter int unsigned BKW        = $clog2(NBANKS);
    parameter int unsigned NTYPES     = 2;
    parameter int unsigned NSLOT      = NPORTS * NTYPES;
    parameter int unsigned WAW        = AW - $clog2(NBE);

    parameter logic [RGW-1:0] RGN_CODE_ROM  = RGW'(0);
    parameter logic [RGW-1:0] RGN_CODE_SRAM = RGW'(1);

    typedef enum logic [1:0] {
        RGN_ROM,
        RGN_SRAM,
        RGN_HOLE
    } region_e;

    typedef enum logic {
        ERR_ILLEGAL = 1'b0,
        ERR_ECC     = 1'b1
    } err_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACCESS,
        ST_READ
    } state_e;

    typedef struct packed {
        logic [PW-1:0]  port;
        logic           write;
        logic [AW-1:0]  addr;
        logic [NBE-1:0] be;
        logic [DW-1:0]  wdata;
    } req_t;

    function automatic logic [DW-1:0] merge_word(
        input logic [DW-1:0]  old_word,
        input logic [DW-1:0]  new_word,
        input logic [NBE-1:0] lanes
    );
        logic [DW-1:0] res;
        res = old_word;
        for (int b = 0; b < int'(NBE); b++) begin
            if (lanes[b]) begin
                res[b*8 +: 8] = new_word[b*8 +: 8];
            end
        end
        return res;
    endfunction

endpackage

// File: rtl/mer_decode.sv
module mer_decode
    import mer_pkg::*;
(
    input  logic [RGW-1:0]    rgn_bits,
    input  logic [BKW-1:0]    bank,
    input  logic              write,
    input  logic [NBE-1:0]    be,
    input  logic [NBANKS-1:0] ecc_en,
    output region_e           region,
    output logic              illegal,
    output logic              ecc_bank,
    output logic              rmw
);

    always_comb begin
        if (rgn_bits == RGN_CODE_ROM) begin
            region = RGN_ROM;
        end else if (rgn_bits == RGN_CODE_SRAM) begin
            region = RGN_SRAM;
        end else begin
            region = RGN_HOLE;
        end
    end

    assign illegal  = (region == RGN_HOLE) || ((region == RGN_ROM) && write);
    assign ecc_bank = (region == RGN_SRAM) && ecc_en[bank];
    assign rmw      = write && ecc_bank && (be != {NBE{1'b1}});

endmodule

// File: rtl/mer_capture.sv
module mer_capture
    import mer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  logic [PW-1:0]     port,
    input  err_e              etype,
    input  logic [AW-1:0]     addr,
    input  logic              wr,
    input  logic              clr_valid,
    input  logic [PW-1:0]     clr_port,
    input  logic              clr_type,
    output logic [NSLOT-1:0]  slot_valid,
    output logic [NSLOT*AW-1:0] slot_addr,
    output logic [NSLOT-1:0]  slot_wr
);

    for (genvar s = 0; s < int'(NSLOT); s++) begin : g_slot
        localparam logic [PW:0] SID = (PW+1)'(s);
        logic hit_cap;
        logic hit_clr;

        assign hit_cap = fire && ({port, etype} == SID);
        assign hit_clr = clr_valid && ({clr_port, clr_type} == SID);

        always_ff @(posedge clk) begin
            if (rst) begin
                slot_valid[s]        <= 1'b0;
                slot_addr[s*AW +: AW] <= '0;
                slot_wr[s]           <= 1'b0;
            end else begin
                if (hit_clr) begin
                    slot_valid[s] <= 1'b0;
                end
                // a clear on the same edge frees the slot for the new error
                if (hit_cap && (!slot_valid[s] || hit_clr)) begin
                    slot_valid[s]        <= 1'b1;
                    slot_addr[s*AW +: AW] <= addr;
                    slot_wr[s]           <= wr;
                end
            end
        end
    end

endmodule

// File: rtl/mem_err_responder.sv
module mem_err_responder
    import mer_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NBANKS-1:0]    ecc_en,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [PW-1:0]        req_port,
    input  logic                 req_write,
    input  logic [AW-1:0]        req_addr,
    input  logic [NBE-1:0]       req_be,
    input  logic [DW-1:0]        req_wdata,
    output logic                 rsp_valid,
    output logic                 rsp_err,
    output logic [DW-1:0]        rsp_rdata,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [WAW-1:0]       mem_addr,
    output logic [NBE-1:0]       mem_be,
    output logic [DW-1:0]        mem_wdata,
    input  logic [DW-1:0]        mem_rdata,
    input  logic                 mem_ecc_multi,
    input  logic                 clr_valid,
    input  logic [PW-1:0]        clr_port,
    input  logic                 clr_type,
    output logic [NSLOT-1:0]     cap_valid,
    output logic [NSLOT*AW-1:0]  cap_addr,
    output logic [NSLOT-1:0]     cap_wr
);

    state_e  state_q, state_d;
    req_t    cur_q;
    region_e cur_region;
    logic    cur_illegal;
    logic    cur_ecc_bank;
    logic    cur_rmw;
    logic    cap_fire;
    err_e    cap_type;

    assign req_ready = (state_q == ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cur_q   <= '0;
        end else begin
            state_q <= state_d;
            if (req_valid && req_ready) begin
                cur_q.port  <= req_port;
                cur_q.write <= req_write;
                cur_q.addr  <= req_addr;
                cur_q.be    <= req_be;
                cur_q.wdata <= req_wdata;
            end
        end
    end

    mer_decode u_decode (
        .rgn_bits (cur_q.addr[AW-1:REGION_LSB]),
        .bank     (cur_q.addr[REGION_LSB-1 -: BKW]),
        .write    (cur_q.write),
        .be       (cur_q.be),
        .ecc_en   (ecc_en),
        .region   (cur_region),
        .illegal  (cur_illegal),
        .ecc_bank (cur_ecc_bank),
        .rmw      (cur_rmw)
    );

    always_comb begin
        state_d   = state_q;
        rsp_valid = 1'b0;
        rsp_err   = 1'b0;
        rsp_rdata = '0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = cur_q.addr[AW-1:AW-WAW];
        mem_be    = cur_q.be;
        mem_wdata = cur_q.wdata;
        cap_fire  = 1'b0;
        cap_type  = ERR_ILLEGAL;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    state_d = ST_ACCESS;
                end
            end
            ST_ACCESS: begin
                if (cur_illegal) begin
                    rsp_valid = 1'b1;
                    rsp_err   = 1'b1;
                    cap_fire  = 1'b1;
                    cap_type  = ERR_ILLEGAL;
                    state_d   = ST_IDLE;
                end else begin
                    mem_req = 1'b1;
                    mem_we  = cur_q.write && !cur_rmw;
                    if (mem_we) begin
                        rsp_valid = 1'b1;
                        state_d   = ST_IDLE;
                    end else begin
                        state_d = ST_READ;
                    end
                end
            end
            ST_READ: begin
                rsp_valid = 1'b1;
                state_d   = ST_IDLE;
                if (cur_q.write) begin
                    // only the read half of a read-modify-write lands here
                    if (mem_ecc_multi) begin
                        rsp_err  = 1'b1;
                        cap_fire = 1'b1;
                        cap_type = ERR_ECC;
                    end else begin
                        mem_req   = 1'b1;
                        mem_we    = 1'b1;
                        mem_be    = {NBE{1'b1}};
                        mem_wdata = merge_word(mem_rdata, cur_q.wdata, cur_q.be);
                    end
                end else if (mem_ecc_multi && cur_ecc_bank) begin
                    rsp_err  = 1'b1;
                    cap_fire = 1'b1;
                    cap_type = ERR_ECC;
                end else begin
                    rsp_rdata = mem_rdata;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    mer_capture u_capture (
        .clk        (clk),
        .rst        (rst),
        .fire       (cap_fire),
        .port       (cur_q.port),
        .etype      (cap_type),
        .addr       (cur_q.addr),
        .wr         (cur_q.write),
        .clr_valid  (clr_valid),
        .clr_port   (clr_port),
        .clr_type   (clr_type),
        .slot_valid (cap_valid),
        .slot_addr  (cap_addr),
        .slot_wr    (cap_wr)
    );

endmodule

// File: rtl/mer_checker.sv
module mer_checker
    import mer_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic [NBANKS-1:0]   ecc_en,
    input logic                req_valid,
    input logic                req_ready,
    input logic [PW-1:0]       req_port,
    input logic                req_write,
    input logic [AW-1:0]       req_addr,
    input logic [NBE-1:0]      req_be,
    input logic                rsp_valid,
    input logic                rsp_err,
    input logic                mem_req,
    input logic                mem_we,
    input logic [NBE-1:0]      mem_be,
    input logic                mem_ecc_multi,
    input logic                clr_valid,
    input logic [PW-1:0]       clr_port,
    input logic                clr_type,
    input logic [NSLOT-1:0]    cap_valid,
    input logic [NSLOT*AW-1:0] cap_addr
);

    logic [AW-1:0]  l_addr;
    logic [PW-1:0]  l_port;
    logic           l_write;
    logic [NBE-1:0] l_be;
    logic           pend_q;
    logic [PW:0]    pend_slot;

    always_ff @(posedge clk) begin
        if (rst) begin
            l_addr  <= '0;
            l_port  <= '0;
            l_write <= 1'b0;
            l_be    <= '0;
        end else if (req_valid && req_ready) begin
            l_addr  <= req_addr;
            l_port  <= req_port;
            l_write <= req_write;
            l_be    <= req_be;
        end
    end

    logic l_rom, l_sram, l_hole, l_prot, l_partial_prot, l_illegal;
    logic [PW:0] l_slot;
    assign l_rom          = (l_addr[AW-1:REGION_LSB] == RGW'(0));
    assign l_sram         = (l_addr[AW-1:REGION_LSB] == RGW'(1));
    assign l_hole         = !l_rom && !l_sram;
    assign l_prot         = l_sram && ecc_en[l_addr[REGION_LSB-1 -: BKW]];
    assign l_partial_prot = l_write && l_prot && (l_be != {NBE{1'b1}});
    assign l_illegal      = l_hole || (l_rom && l_write);
    assign l_slot         = {l_port, !l_illegal};

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q    <= 1'b0;
            pend_slot <= '0;
        end else begin
            pend_q    <= rsp_valid && rsp_err &&
                         (!cap_valid[l_slot] ||
                          (clr_valid && ({clr_port, clr_type} == l_slot)));
            pend_slot <= l_slot;
        end
    end

    p_rom_write_err_r1: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && l_rom && l_write |-> rsp_err && !mem_req);

    p_hole_err_r2: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && l_hole |-> rsp_err && !mem_req);

    p_rmw_full_word_r4: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_we && l_partial_prot |-> mem_be == {NBE{1'b1}});

    p_rmw_suppress_r5: assert property (@(posedge clk) disable iff (rst)
        l_partial_prot && $past(mem_req && !mem_we) && mem_ecc_multi
        |-> rsp_err && !mem_req);

    p_capture_addr_r8: assert property (@(posedge clk) disable iff (rst)
        pend_q |-> cap_valid[pend_slot] && (cap_addr[pend_slot*AW +: AW] == l_addr));

    p_busy_in_resp_r11: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !req_ready);

    for (genvar s = 0; s < int'(NSLOT); s++) begin : g_hold
        localparam logic [PW:0] SID = (PW+1)'(s);
        p_first_kept_r9: assert property (@(posedge clk) disable iff (rst)
            cap_valid[s] && !(clr_valid && ({clr_port, clr_type} == SID))
            |=> cap_valid[s] && $stable(cap_addr[s*AW +: AW]));
    end

endmodule

bind mem_err_responder mer_checker u_mer_checker (.*);

// File: tb/mem_err_responder_bench.sv
module mem_err_responder_bench;
    import mer_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int MEMW = 2048;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NBANKS-1:0] ecc_en = 4'b1011;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [PW-1:0] req_port = '0;
    logic req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [NBE-1:0] req_be = '0;
    logic [DW-1:0] req_wdata = '0;
    logic rsp_valid, rsp_err;
    logic [DW-1:0] rsp_rdata;
    logic mem_req, mem_we;
    logic [WAW-1:0] mem_addr;
    logic [NBE-1:0] mem_be;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata;
    logic mem_ecc_multi;
    logic clr_valid = 1'b0;
    logic [PW-1:0] clr_port = '0;
    logic clr_type = 1'b0;
    logic [NSLOT-1:0] cap_valid;
    logic [NSLOT*AW-1:0] cap_addr;
    logic [NSLOT-1:0] cap_wr;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mem_err_responder u_mem_err_responder (.*);

    // memory model
    logic [DW-1:0] mem [MEMW];
    logic [DW-1:0] rd_q = '0;
    logic multi_q = 1'b0;
    logic inj_multi = 1'b0;
    int wr_cnt = 0;
    int rd_cnt = 0;
    assign mem_rdata = rd_q;
    assign mem_ecc_multi = multi_q;

    always @(posedge clk) begin
        multi_q <= 1'b0;
        if (mem_req) begin
            if (mem_we) begin
                for (int b = 0; b < 4; b++)
                    if (mem_be[b]) mem[mem_addr[10:0]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
                wr_cnt <= wr_cnt + 1;
            end else begin
                rd_q    <= mem[mem_addr[10:0]];
                multi_q <= inj_multi;
                rd_cnt  <= rd_cnt + 1;
            end
        end
    end

    // reference state
    logic [DW-1:0] ref_mem [MEMW];
    logic exp_cv [NSLOT];
    logic [AW-1:0] exp_ca [NSLOT];
    logic exp_cw [NSLOT];

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] lane_merge(input logic [DW-1:0] o, input logic [DW-1:0] n, input logic [3:0] be);
        logic [DW-1:0] r;
        for (int b = 0; b < 4; b++) r[b*8 +: 8] = be[b] ? n[b*8 +: 8] : o[b*8 +: 8];
        return r;
    endfunction

    task automatic check_slots(input string tag);
        for (int s = 0; s < int'(NSLOT); s++) begin
            chk(cap_valid[s] == exp_cv[s], tag, 64'(cap_valid[s]), 64'(exp_cv[s]));
            if (exp_cv[s]) begin
                chk(cap_addr[s*AW +: AW] == exp_ca[s], tag, 64'(cap_addr[s*AW +: AW]), 64'(exp_ca[s]));
                chk(cap_wr[s] == exp_cw[s], tag, 64'(cap_wr[s]), 64'(exp_cw[s]));
            end
        end
    endtask

    task automatic do_txn(input logic [1:0] port, input logic wr, input logic [15:0] addr,
                          input logic [3:0] be, input logic [31:0] wd, input logic multi,
                          input bit clr_same);
        logic rom, sram, hole, illegal, prot, rmw, exp_err;
        int exp_lat, lat, wc0, rc0, exp_wc, exp_rc, slot;
        logic [DW-1:0] exp_rd;
        rom  = (addr[15:12] == 4'd0);
        sram = (addr[15:12] == 4'd1);
        hole = !rom && !sram;
        illegal = hole || (rom && wr);
        prot = sram && ecc_en[addr[11:10]];
        rmw  = wr && prot && (be != 4'hF);
        exp_err = illegal || (prot && multi && (!wr || rmw));
        exp_lat = (illegal || (wr && !rmw)) ? 1 : 2;
        exp_rc  = (!illegal && (!wr || rmw)) ? 1 : 0;
        exp_wc  = (!illegal && wr && !(rmw && multi)) ? 1 : 0;
        exp_rd  = (!wr && !exp_err) ? ref_mem[addr[12:2]] : '0;
        slot    = port * 2 + (illegal ? 0 : 1);

        @(negedge clk);
        chk(req_ready == 1'b1, "R11", 64'(req_ready), 64'd1);
        req_valid = 1'b1; req_port = port; req_write = wr; req_addr = addr;
        req_be = be; req_wdata = wd; inj_multi = multi;
        wc0 = wr_cnt; rc0 = rd_cnt;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!rsp_valid && lat < 8) begin
            @(negedge clk);
            lat++;
        end
        chk(lat == exp_lat, "R11", 64'(lat), 64'(exp_lat));
        chk(req_ready == 1'b0, "R11", 64'(req_ready), 64'd0);
        chk(rsp_err == exp_err, illegal ? (hole ? "R2" : "R1") : (rmw ? "R5" : "R3"),
            64'(rsp_err), 64'(exp_err));
        chk(rsp_rdata == exp_rd, "R6", 64'(rsp_rdata), 64'(exp_rd));
        if (clr_same) begin
            clr_valid = 1'b1; clr_port = slot[2:1]; clr_type = slot[0];
        end
        @(negedge clk);
        clr_valid = 1'b0; inj_multi = 1'b0;
        chk(rd_cnt - rc0 == exp_rc, rmw ? "R4" : "R7", 64'(rd_cnt - rc0), 64'(exp_rc));
        chk(wr_cnt - wc0 == exp_wc, rmw ? "R5" : "R7", 64'(wr_cnt - wc0), 64'(exp_wc));
        if (!illegal && wr && !(rmw && multi))
            ref_mem[addr[12:2]] = lane_merge(ref_mem[addr[12:2]], wd, be);
        if (!hole)
            chk(mem[addr[12:2]] == ref_mem[addr[12:2]], rmw ? "R4" : "R7",
                64'(mem[addr[12:2]]), 64'(ref_mem[addr[12:2]]));
        if (clr_same) exp_cv[slot] = 1'b0;
        if (exp_err && !exp_cv[slot]) begin
            exp_cv[slot] = 1'b1; exp_ca[slot] = addr; exp_cw[slot] = wr;
        end
        check_slots(clr_same ? "R10" : "R8");
    endtask

    task automatic do_clear(input int slot);
        @(negedge clk);
        clr_valid = 1'b1; clr_port = slot[2:1]; clr_type = slot[0];
        @(negedge clk);
        clr_valid = 1'b0;
        exp_cv[slot] = 1'b0;
        check_slots("R10");
    endtask

    function automatic logic [15:0] pick_addr(input int kind);
        logic [15:0] a;
        a = 16'($urandom);
        case (kind)
            0: a[15:12] = 4'd0;
            1: a[15:12] = 4'd1;
            default: a[15:12] = 4'(2 + ($urandom % 14));
        endcase
        return a;
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h1d2c3b4a));
        for (int i = 0; i < MEMW; i++) begin
            mem[i] = $urandom;
            ref_mem[i] = mem[i];
        end
        for (int s = 0; s < int'(NSLOT); s++) begin
            exp_cv[s] = 1'b0; exp_ca[s] = '0; exp_cw[s] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1 && rsp_valid == 1'b0 && mem_req == 1'b0, "R11",
            64'({req_ready, rsp_valid, mem_req}), 64'b100);
        chk(cap_valid == '0, "R8", 64'(cap_valid), 64'd0);

        // directed corners
        do_txn(2'd0, 1'b1, 16'h0124, 4'hF, 32'hdeadbeef, 1'b0, 0);  // R1 write to ROM
        do_txn(2'd0, 1'b0, 16'h0124, 4'hF, 32'h0, 1'b0, 0);         // R1 ROM read legal
        do_txn(2'd1, 1'b0, 16'h3000, 4'hF, 32'h0, 1'b0, 0);         // R2 hole read
        do_txn(2'd1, 1'b1, 16'hF00C, 4'h1, 32'h0, 1'b0, 0);         // R2 hole write
        do_txn(2'd2, 1'b0, 16'h1010, 4'hF, 32'h0, 1'b1, 0);         // R3 protected read multi
        do_txn(2'd2, 1'b0, 16'h1810, 4'hF, 32'h0, 1'b1, 0);         // R3 unprotected bank ignores
        do_txn(2'd3, 1'b1, 16'h1404, 4'b0101, 32'h11223344, 1'b0, 0); // R4 merge
        do_txn(2'd3, 1'b1, 16'h1408, 4'b0010, 32'h55667788, 1'b1, 0); // R5 suppressed
        do_txn(2'd3, 1'b1, 16'h1C00, 4'hF, 32'hcafef00d, 1'b1, 0);  // R7 full word, no read
        do_txn(2'd3, 1'b1, 16'h1A00, 4'b1000, 32'haabbccdd, 1'b0, 0); // R7 unprotected partial
        do_txn(2'd0, 1'b0, 16'h5554, 4'hF, 32'h0, 1'b0, 0);         // R9 same slot, first kept
        do_txn(2'd0, 1'b1, 16'h0200, 4'hF, 32'h1, 1'b0, 1);         // R10 clear + capture together
        do_txn(2'd3, 1'b1, 16'h1000, 4'b0001, 32'h9, 1'b1, 1);      // R10 on ECC slot
        do_clear(3);                                                 // R10 plain clear
        do_txn(2'd1, 1'b0, 16'h1004, 4'hF, 32'h0, 1'b1, 0);         // R8 port 1 type 1

        // random mix
        for (int n = 0; n < 400; n++) begin
            int kind;
            kind = ($urandom % 10 < 2) ? 0 : (($urandom % 10 < 8) ? 1 : 2);
            if ($urandom % 8 == 0) do_clear(int'($urandom % NSLOT));
            do_txn(2'($urandom), 1'($urandom), pick_addr(kind),
                   ($urandom % 2 == 0) ? 4'hF : 4'($urandom),
                   $urandom, ($urandom % 4 == 0), ($urandom % 16 == 0));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule